// File: doc/BRIEF.md
# DDR Burst-of-Four SRAM Core

This block is a synthesizable behavioural model of the core of a common-I/O static RAM that transfers data at double rate in fixed bursts of four. Commands arrive on the rising edges of a main clock. Data beats are timed by `clk`, a beat clock that runs at twice the main-clock rate. The `k_phase` output tells the driver which beat edges are main-clock edges. A main-clock edge with `ld_n` low starts a command. `rw` high makes it a read and `rw` low makes it a write. The burst starts at `addr`, and the two low address bits count upward modulo four while the upper bits stay fixed.

Writes are late: the four data beats follow the command, and each beat has its own active-low lane enables. The captured beats go into a four-slot buffer. Each slot is written into the array only when the same beat position of the next write takes its place. Reads look at the buffer before the array, so a read always returns the most recent data written. Read beats come out of a register with an output-enable and a beat-valid strobe in place of a tristate pad. A command issued too soon after an accepted one is dropped and flagged.

Top module: `ddr4b_sram_core`

## Requirements
- R1: Commands are sampled only on beat edges that follow a beat with `k_phase` high (main edges). `k_phase` alternates every beat and is high in the first beat after reset is released. At a main edge, `ld_n` low starts a command: `rw`=1 is a read and `rw`=0 is a write. On all other edges, `ld_n`, `rw` and `addr` have no effect.
- R2: A read accepted at beat edge n drives `q_vld` and `q_oe` high after edges n+3, n+4, n+5 and n+6, which is four consecutive beats starting 1.5 main cycles after the command.
- R3: The four beats of a burst use the addresses {upper, s}, {upper, s+1}, {upper, s+2}, {upper, s+3}. Here s is `addr[1:0]`, the sum wraps modulo 4, and the upper bits are unchanged.
- R4: A write accepted at beat edge n captures `d` and `bwe_n` at edges n+2, n+3, n+4 and n+5, one beat for each burst address in order.
- R5: On a write beat, `bwe_n[l]` low writes lane l, which is bits l*9 to l*9+8. A lane whose bit is high keeps its old value, and all bits high aborts that beat. `d` and `bwe_n` outside write beats have no effect.
- R6: Each read beat returns the newest data written to its address. This includes data still held in the write buffer, for example in a read accepted two main cycles after a write to the same burst.
- R7: A command at the main edge directly after an accepted command is ignored and produces no beats. `perr` is high for exactly the one beat after that edge.
- R8: `ld_n` high at a main edge is a NOP and does not cut short a read burst in progress. When no read beat is being driven, `q_oe` and `q_vld` are low and `q` is zero.
- R9: While reset is held and in the first beat after it is released, `q_oe`, `q_vld` and `perr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, twice the main-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Command strobe, active low, sampled at main edges |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW (8) | Burst start address |
| d | input | DW (18) | Write data beat |
| bwe_n | input | LANES (2) | Active-low lane write enables for the current beat |
| q | output | DW (18) | Read data beat, zero when not driven |
| q_oe | output | 1 | Output enable for `q` |
| q_vld | output | 1 | Read beat valid strobe |
| perr | output | 1 | Too-early command was ignored |
| k_phase | output | 1 | High when the next beat edge is a main edge |

## Verification
The hardest case to reach is a read whose data lives only in the write buffer. This needs a read two main cycles after a write that covers the same four addresses, so that no later write has yet pushed the buffered beats into the array. It also needs partial lane masks, so the forwarded lanes and the array lanes differ. Directed sequences build this case with wrapped start addresses. They also place a write right after a read so that the first write beat lands on the same edge as the last read beat. The random phase then draws addresses from a small window, which makes buffer hits, aborted beats and too-early commands frequent.

// File: rtl/ddr4b_sram_core.sv
module ddr4b_sram_core #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 256
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ld_n,
  input  logic                             rw,
  input  logic [$clog2(DEPTH)-1:0]         addr,
  input  logic [LANE_W*LANES-1:0]          d,
  input  logic [LANES-1:0]                 bwe_n,
  output logic [LANE_W*LANES-1:0]          q,
  output logic                             q_oe,
  output logic                             q_vld,
  output logic                             perr,
  output logic                             k_phase
);
  localparam int DW = LANE_W * LANES;
  localparam int AW = $clog2(DEPTH);
  localparam int HD = 6;

  logic          ph;
  logic [HD:1]   hv, hw;
  logic [AW-1:0] ha [1:HD];

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    sd  [4];
  logic [LANES-1:0] sm  [4];
  logic [AW-1:0]    sa  [4];
  logic [3:0]       sv;

  logic [DW-1:0] q_r, fwd;
  logic          on_r, perr_r;
  logic          rd_go, wr_go;
  logic [AW-1:0] rd_a, wr_a;
  logic [1:0]    wr_k;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  assign k_phase = ~ph;
  wire req = ~ph & ~ld_n;
  wire acc = req & ~hv[2];

  always_comb begin
    rd_go = 1'b0; rd_a = '0;
    wr_go = 1'b0; wr_a = '0; wr_k = '0;
    for (int k = 0; k < 4; k++) begin
      if (hv[k+3] && !hw[k+3]) begin
        rd_go = 1'b1;
        rd_a  = bump(ha[k+3], k);
      end
      if (hv[k+2] && hw[k+2]) begin
        wr_go = 1'b1;
        wr_k  = 2'(k);
        wr_a  = bump(ha[k+2], k);
      end
    end
  end

  always_comb begin
    fwd = mem[rd_a];
    for (int s = 0; s < 4; s++)
      if (sv[s] && sa[s] == rd_a)
        for (int l = 0; l < LANES; l++)
          if (sm[s][l]) fwd[l*LANE_W +: LANE_W] = sd[s][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= 1'b0;
      hv     <= '0;
      hw     <= '0;
      for (int i = 1; i <= HD; i++) ha[i] <= '0;
      sv     <= '0;
      q_r    <= '0;
      on_r   <= 1'b0;
      perr_r <= 1'b0;
    end else begin
      ph     <= ~ph;
      hv     <= {hv[HD-1:1], acc};
      hw     <= {hw[HD-1:1], ~rw};
      ha[1]  <= addr;
      for (int i = 2; i <= HD; i++) ha[i] <= ha[i-1];
      perr_r <= req & hv[2];
      on_r   <= rd_go;
      q_r    <= rd_go ? fwd : '0;
      if (wr_go) sv[wr_k] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (sv[wr_k])
        for (int l = 0; l < LANES; l++)
          if (sm[wr_k][l])
            mem[sa[wr_k]][l*LANE_W +: LANE_W] <= sd[wr_k][l*LANE_W +: LANE_W];
      sd[wr_k] <= d;
      sm[wr_k] <= ~bwe_n;
      sa[wr_k] <= wr_a;
    end
  end

  assign q     = q_r;
  assign q_oe  = on_r;
  assign q_vld = on_r;
  assign perr  = perr_r;
endmodule

// File: rtl/ddr4b_sram_core_chk.sv
module ddr4b_sram_core_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_n,
  input logic          rw,
  input logic [DW-1:0] q,
  input logic          q_oe,
  input logic          q_vld,
  input logic          perr,
  input logic          k_phase
);
  a_r1_phase_hi: assert property (@(posedge clk) disable iff (!rst_n)
    k_phase |=> !k_phase);
  a_r1_phase_lo: assert property (@(posedge clk) disable iff (!rst_n)
    !k_phase |=> k_phase);
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_vld) |-> $past(k_phase && !ld_n && rw, 4));
  a_r2_burst_four: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_vld) |-> q_vld ##1 q_vld ##1 q_vld ##1 q_vld);
  a_r7_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    perr |-> $past(k_phase && !ld_n));
  a_r7_perr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    perr |=> !perr);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !q_oe |-> q == '0);
endmodule

bind ddr4b_sram_core ddr4b_sram_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .q(q),
  .q_oe(q_oe), .q_vld(q_vld), .perr(perr), .k_phase(k_phase)
);

// File: tb/ddr4b_sram_core_tb.sv
module ddr4b_sram_core_tb;
  localparam int LW = 9, LN = 2, DW = 18, DEPTH = 256, AW = 8;
  localparam int NRAND = 2000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ld_n, rw;
  logic [AW-1:0] addr;
  logic [DW-1:0] d, q;
  logic [LN-1:0] bwe_n;
  logic q_oe, q_vld, perr, k_phase;

  ddr4b_sram_core #(.LANE_W(LW), .LANES(LN), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr), .d(d),
    .bwe_n(bwe_n), .q(q), .q_oe(q_oe), .q_vld(q_vld), .perr(perr), .k_phase(k_phase)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ev [16];
  logic [DW-1:0] eq [16];
  bit            ep [16];
  bit            rs_v [16];
  logic [AW-1:0] rs_a [16];
  bit            ws_v [16];
  bit            ws_f [16];
  logic [AW-1:0] ws_a [16];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input int k);
    return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
  endfunction

  // kind: 0 = NOP, 1 = read, 2 = write; full: all lanes enabled
  task automatic pick(input int m, output int kind, output logic [AW-1:0] a, output bit full);
    int j, r;
    full = 0; a = '0; kind = 0;
    if (m < 128) begin
      if (m % 2 == 0) begin kind = 2; a = AW'((m / 2) * 4); full = 1; end
    end else if (m < 160) begin
      j = m - 128;
      case (j)
        0:  begin kind = 2; a = 8'h12; end
        1:  begin kind = 1; a = 8'h40; end   // too early: R7
        2:  begin kind = 1; a = 8'h13; end   // buffered hit: R6
        4:  begin kind = 1; a = 8'h10; end
        6:  begin kind = 2; a = 8'h22; end
        8:  begin kind = 2; a = 8'h21; end
        10: begin kind = 1; a = 8'h23; end
        12: begin kind = 1; a = 8'h20; end
        14: begin kind = 1; a = 8'h24; end
        16: begin kind = 2; a = 8'h24; end   // first write beat meets last read beat
        17: begin kind = 2; a = 8'h50; end   // too early: R7
        18: begin kind = 1; a = 8'h26; end
        default: kind = 0;
      endcase
    end else if (m < 160 + NRAND) begin
      r = int'($urandom % 8);
      kind = (r < 3) ? 0 : (r < 5) ? 1 : 2;
      a = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 24);
    end
  endtask

  initial begin
    int last_acc, kind, p, c;
    logic [AW-1:0] a;
    bit full;
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) begin ev[i] = 0; ep[i] = 0; rs_v[i] = 0; ws_v[i] = 0; end
    rst_n = 1'b0; ld_n = 1'b1; rw = 1'b1; addr = '0; d = '0; bwe_n = '1;
    repeat (3) @(negedge clk);
    chk("R9 q_oe in reset", 32'(q_oe), 0);
    chk("R9 perr in reset", 32'(perr), 0);
    rst_n = 1'b1;
    chk("R9 q_vld after release", 32'(q_vld), 0);
    last_acc = -100;
    for (int e = 0; e < 2 * (160 + NRAND + 8); e++) begin
      c = e % 16;
      if (e > 0) begin
        p = (e - 1) % 16;
        chk("R2 q_vld", 32'(q_vld), 32'(ev[p]));
        chk("R2 q_oe", 32'(q_oe), 32'(ev[p]));
        // data beats exercise R3 order, R4 capture timing, R5 lanes
        if (ev[p]) chk("R3/R4/R5/R6 read data", 32'(q), 32'(eq[p]));
        else       chk("R8 idle q zero", 32'(q), 0);
        chk("R7 perr", 32'(perr), 32'(ep[p]));
        ev[p] = 0; ep[p] = 0;
      end
      chk("R1 k_phase", 32'(k_phase), 32'(e % 2 == 0));
      if (rs_v[c]) begin ev[c] = 1; eq[c] = ref_mem[rs_a[c]]; rs_v[c] = 0; end
      if (e % 2 == 0) begin
        pick(e / 2, kind, a, full);
        ld_n = (kind == 0); rw = (kind != 2); addr = a;
        if (kind != 0) begin
          if (e - 2 == last_acc) ep[c] = 1;
          else begin
            last_acc = e;
            for (int k = 0; k < 4; k++) begin
              if (kind == 1) begin rs_v[(e+3+k)%16] = 1; rs_a[(e+3+k)%16] = nxt(a, k); end
              else begin
                ws_v[(e+2+k)%16] = 1; ws_a[(e+2+k)%16] = nxt(a, k); ws_f[(e+2+k)%16] = full;
              end
            end
          end
        end
      end else begin
        // off-phase command inputs must be ignored: R1
        ld_n = 1'($urandom); rw = 1'($urandom); addr = AW'($urandom);
      end
      d = DW'($urandom);
      bwe_n = LN'($urandom);
      if (ws_v[c]) begin
        if (ws_f[c]) bwe_n = '0;
        for (int l = 0; l < LN; l++)
          if (!bwe_n[l]) ref_mem[ws_a[c]][l*LW +: LW] = d[l*LW +: LW];
        ws_v[c] = 0;
      end
      @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule